// File: doc/BRIEF.md
# Non-overlapping Bus Grant Sequencer

This block arbitrates a shared external bus among several masters that take ownership asynchronously. A master sees its active-low grant, passes it through its own synchronizer, and then pulls a shared active-low busy line. Because of that synchronizer latency, a master can still start driving busy a little after its grant has been withdrawn. A second master granted too early could then take the bus at the same moment.

The sequencer grants one master at a time, chosen round-robin after the previous owner. It keeps the grant while the master requests, up to a tenure limit. After a release it waits out a guard window. That window covers the late-busy interval plus the minimum busy-to-grant delay, and any newly observed busy assertion restarts the busy-to-grant timer. The busy line passes through a two-flop synchronizer before any decision uses it. A busy assertion that appears when no grant could explain it raises a one-cycle error pulse. An enable input stands in for the masters' asynchronous-arbitration mode and forces every grant inactive while low.

Top module: `nonoverlap_grant_seq`

## Requirements
- R1: While `rst` is high, every bit of `grant_n` is 1 (inactive) and `proto_err` is 0, whatever `req` and `arb_en` do.
- R2: At most one bit of `grant_n` is 0 in any cycle.
- R3: `busy_n` is sampled through a two-stage synchronizer, so a change first affects decisions two clock edges after it is sampled. No new grant is started while the synchronized busy reads asserted.
- R4: Between the removal of one grant and the start of the next there are at least LATE_CYC + B2G_CYC clock cycles with all grants inactive. The defaults are 5 + 3.
- R5: Once a rising edge of synchronized busy is observed, no new grant starts for the following B2G_CYC clock edges.
- R6: The new owner is the first requesting master at index last+1, last+2, ... modulo N_MASTERS, where last is the most recent owner. Right after reset, last is N_MASTERS-1, so master 0 is tried first.
- R7: A grant stays active while its master's `req` bit is 1. It ends at the first clock edge that samples the bit at 0, or after MAX_TENURE consecutive cycles. The default MAX_TENURE is 12.
- R8: While `arb_en` is 0, all `grant_n` bits read 1 in the same cycle, the current grant is released at the next edge, and no new grant starts.
- R9: `proto_err` pulses high for one cycle, one edge after a rising edge of synchronized busy is seen. This happens only when no grant is held and more than LATE_CYC edges have passed since the last release, or when there has been no release since reset. A rise inside the late window is not flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Arbiter clock |
| rst | input | 1 | Synchronous active-high reset |
| arb_en | input | 1 | Enables asynchronous arbitration; low forces all grants inactive |
| req | input | N_MASTERS | Active-high bus request, one bit per master |
| busy_n | input | 1 | Shared active-low bus-busy line, asynchronous to clk |
| grant_n | output | N_MASTERS | Active-low bus grant, one bit per master |
| proto_err | output | 1 | One-cycle pulse on an unexplained busy assertion |

## Verification
Two functions meet in the same cycle when the enable drops on the very edge where a new grant would start, or when an observed busy rise coincides with a release, so that both guard timers reload together and the error decision must use the pre-release state. Random enable flapping, request changes every few cycles and sporadic injected busy pulses provoke both overlaps many times. A behavioural per-cycle model in the bench, built on elapsed-cycle counts rather than down-counters, predicts every grant and error bit and judges each cycle. Directed cases pin the busy-blocked wait, the busy-to-grant hold-off and the inside/outside-window error distinction.

// File: rtl/ngs_pkg.sv
package ngs_pkg;

    // Arbiter ownership state
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_OWN  = 1'b1
    } arb_state_e;

    // Status of the two guard timers as seen by the grant FSM
    typedef struct packed {
        logic gap_clear;   // release-to-grant spacing has elapsed
        logic b2g_clear;   // busy-to-grant hold-off has elapsed
        logic late_open;   // still inside the late-busy window after a release
    } guard_stat_t;

    // Bits needed to hold the values 0 .. n-1 (at least one bit)
    function automatic int idx_width(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/ngs_sync.sv
module ngs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/ngs_rr.sv
module ngs_rr #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req_i,
    input  logic [IDX_W-1:0] last_i,
    output logic             any_o,
    output logic [IDX_W-1:0] pick_o
);
    // Scan from the master after the last owner, wrapping once around.
    always_comb begin
        any_o  = 1'b0;
        pick_o = last_i;
        for (int k = 1; k <= N; k++) begin
            int j;
            j = (int'(last_i) + k) % N;
            if (!any_o && req_i[j]) begin
                any_o  = 1'b1;
                pick_o = IDX_W'(j);
            end
        end
    end

endmodule

// File: rtl/ngs_guard.sv
module ngs_guard
    import ngs_pkg::*;
#(
    parameter int LATE_CYC = 5,
    parameter int B2G_CYC  = 3,
    parameter int CW       = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        release_i,
    input  logic        rise_i,
    output guard_stat_t stat_o
);
    localparam int GAP_CYC = LATE_CYC + B2G_CYC;

    logic [CW-1:0] gap_q;
    logic [CW-1:0] b2g_q;

    // Release-to-grant spacing: covers the late-busy window and the hold-off.
    always_ff @(posedge clk) begin
        if (rst)              gap_q <= '0;
        else if (release_i)   gap_q <= CW'(GAP_CYC);
        else if (gap_q != '0) gap_q <= gap_q - 1'b1;
    end

    // Busy-to-grant hold-off, restarted by every observed busy rise.
    always_ff @(posedge clk) begin
        if (rst)              b2g_q <= '0;
        else if (rise_i)      b2g_q <= CW'(B2G_CYC);
        else if (b2g_q != '0) b2g_q <= b2g_q - 1'b1;
    end

    always_comb begin
        stat_o.gap_clear = (gap_q == '0);
        stat_o.b2g_clear = (b2g_q == '0);
        stat_o.late_open = (gap_q != '0) && (gap_q >= CW'(B2G_CYC));
    end

    // R5: an observed rise arms the full hold-off on the next edge
    a_r5_b2g_reload: assert property (@(posedge clk) disable iff (rst)
        rise_i |=> (b2g_q == CW'(B2G_CYC)));

    // R4: a release arms the full spacing on the next edge
    a_r4_gap_reload: assert property (@(posedge clk) disable iff (rst)
        release_i |=> (gap_q == CW'(GAP_CYC)));

endmodule

// File: rtl/nonoverlap_grant_seq.sv
module nonoverlap_grant_seq
    import ngs_pkg::*;
#(
    parameter int N_MASTERS   = 4,
    parameter int LATE_CYC    = 5,
    parameter int B2G_CYC     = 3,
    parameter int MAX_TENURE  = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 arb_en,
    input  logic [N_MASTERS-1:0] req,
    input  logic                 busy_n,
    output logic [N_MASTERS-1:0] grant_n,
    output logic                 proto_err
);
    localparam int IDX_W   = idx_width(N_MASTERS);
    localparam int TEN_W   = idx_width(MAX_TENURE);
    localparam int GAP_CYC = LATE_CYC + B2G_CYC;
    localparam int GCW     = idx_width(GAP_CYC + 1);

    typedef struct packed {
        arb_state_e       st;
        logic [IDX_W-1:0] owner;
        logic [TEN_W-1:0] tenure;
    } own_t;

    own_t             cur_q, nxt;
    logic [IDX_W-1:0] last_q;
    logic [IDX_W-1:0] pick_idx;
    logic             any_req;
    logic             busy_act, busy_seen, busy_seen_q, busy_rise;
    logic             do_release;
    logic             proto_err_q;
    guard_stat_t      gstat;

    // ---------------- busy synchronizer and edge detect ----------------
    assign busy_act = ~busy_n;

    ngs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (busy_act),
        .q_o (busy_seen)
    );

    always_ff @(posedge clk) begin
        if (rst) busy_seen_q <= 1'b0;
        else     busy_seen_q <= busy_seen;
    end

    assign busy_rise = busy_seen & ~busy_seen_q;

    // ---------------- round-robin choice ----------------
    ngs_rr #(.N(N_MASTERS), .IDX_W(IDX_W)) u_rr (
        .req_i  (req),
        .last_i (last_q),
        .any_o  (any_req),
        .pick_o (pick_idx)
    );

    // ---------------- guard timers ----------------
    ngs_guard #(.LATE_CYC(LATE_CYC), .B2G_CYC(B2G_CYC), .CW(GCW)) u_guard (
        .clk       (clk),
        .rst       (rst),
        .release_i (do_release),
        .rise_i    (busy_rise),
        .stat_o    (gstat)
    );

    // ---------------- grant FSM ----------------
    always_comb begin
        nxt        = cur_q;
        do_release = 1'b0;
        case (cur_q.st)
            ST_IDLE: begin
                if (arb_en && any_req && !busy_seen &&
                    gstat.gap_clear && gstat.b2g_clear) begin
                    nxt.st     = ST_OWN;
                    nxt.owner  = pick_idx;
                    nxt.tenure = '0;
                end
            end
            ST_OWN: begin
                if (!arb_en || !req[cur_q.owner] ||
                    cur_q.tenure == TEN_W'(MAX_TENURE - 1)) begin
                    do_release = 1'b1;
                    nxt.st     = ST_IDLE;
                    nxt.tenure = '0;
                end else begin
                    nxt.tenure = cur_q.tenure + 1'b1;
                end
            end
            default: nxt = cur_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.st     <= ST_IDLE;
            cur_q.owner  <= '0;
            cur_q.tenure <= '0;
            last_q       <= IDX_W'(N_MASTERS - 1);
        end else begin
            cur_q <= nxt;
            if (do_release) last_q <= cur_q.owner;
        end
    end

    // ---------------- protocol error ----------------
    always_ff @(posedge clk) begin
        if (rst) proto_err_q <= 1'b0;
        else     proto_err_q <= busy_rise && (cur_q.st == ST_IDLE) && !gstat.late_open;
    end

    assign proto_err = proto_err_q;

    // ---------------- grant outputs ----------------
    generate
        for (genvar g = 0; g < N_MASTERS; g++) begin : g_grant
            assign grant_n[g] = ~(arb_en && (cur_q.st == ST_OWN) &&
                                  (cur_q.owner == IDX_W'(g)));
        end
    endgenerate

    // ---------------- assertions ----------------
    a_r2_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~grant_n));

    a_r3_busy_blocks: assert property (@(posedge clk) disable iff (rst)
        (cur_q.st == ST_IDLE && busy_seen) |=> (cur_q.st == ST_IDLE));

    a_r4_spacing_hold: assert property (@(posedge clk) disable iff (rst)
        (cur_q.st == ST_IDLE && !gstat.gap_clear) |=> (cur_q.st == ST_IDLE));

    a_r5_holdoff: assert property (@(posedge clk) disable iff (rst)
        (cur_q.st == ST_IDLE && !gstat.b2g_clear) |=> (cur_q.st == ST_IDLE));

    a_r6_owner_requested: assert property (@(posedge clk) disable iff (rst)
        (cur_q.st == ST_OWN && $past(cur_q.st) == ST_IDLE) |->
        ((($past(req) >> cur_q.owner) & N_MASTERS'(1)) != '0));

    a_r7_tenure_cap: assert property (@(posedge clk) disable iff (rst)
        (cur_q.st == ST_OWN) |-> (int'(cur_q.tenure) < MAX_TENURE));

    a_r8_no_start_disabled: assert property (@(posedge clk) disable iff (rst)
        (cur_q.st == ST_IDLE && !arb_en) |=> (cur_q.st == ST_IDLE));

    a_r9_err_when_idle: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> ($past(cur_q.st) == ST_IDLE));

endmodule

// File: tb/nonoverlap_grant_seq_test.sv
`timescale 1ns/1ps
module nonoverlap_grant_seq_test;
    localparam int N    = 4;
    localparam int LATE = 5;
    localparam int B2G  = 3;
    localparam int MAXT = 12;
    localparam int GAP  = LATE + B2G;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         arb_en = 1'b0;
    logic [N-1:0] req = '0;
    logic         busy_n;
    logic [N-1:0] grant_n;
    logic         proto_err;

    logic emu_busy = 1'b0;
    logic rogue    = 1'b0;
    int   hold = 0;
    int   hold_cfg = 2;
    int   total = 0, bad = 0, err_cnt = 0;
    bit   chk_on = 1'b0;

    assign busy_n = ~(emu_busy | rogue);

    always #5 clk = ~clk;

    nonoverlap_grant_seq #(
        .N_MASTERS(N), .LATE_CYC(LATE), .B2G_CYC(B2G),
        .MAX_TENURE(MAXT), .SYNC_STAGES(2)
    ) uut (
        .clk(clk), .rst(rst), .arb_en(arb_en), .req(req),
        .busy_n(busy_n), .grant_n(grant_n), .proto_err(proto_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Emulated masters: drive busy while granted, hold it a little after.
    always @(negedge clk) begin
        if (rst) begin
            emu_busy <= 1'b0;
            hold     <= 0;
        end else if (grant_n != '1) begin
            emu_busy <= 1'b1;
            hold     <= hold_cfg;
        end else if (hold > 0) begin
            hold <= hold - 1;
        end else begin
            emu_busy <= 1'b0;
        end
    end

    // Behavioural reference: elapsed-cycle counts, not down-counters.
    bit m_h1, m_h2, m_prev, m_gr, m_err;
    int m_own, m_last, m_ten, m_srel, m_srise;

    always @(posedge clk) begin
        if (rst) begin
            m_h1 = 0; m_h2 = 0; m_prev = 0; m_gr = 0; m_err = 0;
            m_own = 0; m_last = N - 1; m_ten = 0; m_srel = 1000; m_srise = 1000;
        end else begin
            bit rise, rel, found;
            rise = m_h2 && !m_prev;
            rel  = 0;
            m_err = rise && !m_gr && (m_srel > LATE);
            if (m_gr) begin
                if (!arb_en || !req[m_own] || m_ten == MAXT - 1) begin
                    m_gr = 0; m_last = m_own; rel = 1;
                end else begin
                    m_ten++;
                end
            end else if (arb_en && req != '0 && !m_h2 && m_srel >= GAP && m_srise >= B2G) begin
                found = 0;
                for (int k = 1; k <= N; k++) begin
                    int j;
                    j = (m_last + k) % N;
                    if (!found && req[j]) begin
                        found = 1; m_own = j;
                    end
                end
                m_gr = 1; m_ten = 0;
            end
            m_srel  = rel  ? 0 : (m_srel  < 1000 ? m_srel + 1  : m_srel);
            m_srise = rise ? 0 : (m_srise < 1000 ? m_srise + 1 : m_srise);
            m_prev = m_h2; m_h2 = m_h1; m_h1 = !busy_n;
        end
    end

    // Per-cycle comparison, away from the active edge.
    logic [N-1:0] prev_g = '1;
    int  off_run = 0, on_run = 0;
    bit  had_grant = 0;

    always @(negedge clk) begin
        #2;
        if (!rst && chk_on) begin
            logic [N-1:0] expg;
            expg = (m_gr && arb_en) ? ~(N'(1) << m_own) : '1;
            check(grant_n === expg, "R6 R7 grant vs model", int'(grant_n), int'(expg));
            check(proto_err === m_err, "R9 error flag vs model", int'(proto_err), int'(m_err));
            check($countones(~grant_n) <= 1, "R2 single grant", $countones(~grant_n), 1);
            if (!arb_en) check(grant_n == '1, "R8 disabled grants", int'(grant_n), int'({N{1'b1}}));
            if (proto_err) err_cnt++;
            if (grant_n == '1) begin
                off_run++;
            end else begin
                if (prev_g == '1 && had_grant)
                    check(off_run >= GAP, "R4 release-to-grant spacing", off_run, GAP);
                on_run = (grant_n == prev_g) ? on_run + 1 : 1;
                check(on_run <= MAXT, "R7 tenure limit", on_run, MAXT);
                had_grant = 1;
                off_run = 0;
            end
            prev_g = grant_n;
        end
    end

    initial begin
        #(200000 * 10);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int e0;
        // R1: reset dominates active inputs
        rst = 1; arb_en = 1; req = '1;
        repeat (4) @(negedge clk);
        #2;
        check(grant_n == '1, "R1 reset grants", int'(grant_n), int'({N{1'b1}}));
        check(proto_err == 1'b0, "R1 reset error", int'(proto_err), 0);
        @(negedge clk);
        rst = 0; chk_on = 1;

        // All masters requesting: round robin and tenure expiry (R6, R7)
        repeat (150) @(negedge clk);

        // Enable low (R8)
        arb_en = 0;
        repeat (20) @(negedge clk);
        arb_en = 1;

        // R3: busy held while a request waits; no grant; unexplained busy flagged (R9)
        req = '0;
        repeat (30) @(negedge clk);
        e0 = err_cnt;
        rogue = 1;
        repeat (2) @(negedge clk);
        req = 4'b0100;
        repeat (12) begin
            @(negedge clk); #3;
            check(grant_n == '1, "R3 busy blocks grant", int'(grant_n), int'({N{1'b1}}));
        end
        rogue = 0;
        repeat (20) @(negedge clk);
        check(err_cnt == e0 + 1, "R9 idle busy flagged", err_cnt - e0, 1);

        // R5: a one-cycle busy pulse holds off a new grant
        req = '0;
        repeat (30) @(negedge clk);
        rogue = 1;
        @(negedge clk);
        rogue = 0;
        @(negedge clk);
        req = 4'b0100;
        repeat (B2G) begin
            @(negedge clk); #3;
            check(grant_n == '1, "R5 busy-to-grant hold-off", int'(grant_n), int'({N{1'b1}}));
        end
        repeat (20) @(negedge clk);

        // R9: late busy inside the window is not flagged
        hold_cfg = 0;
        req = 4'b0010;
        for (int w = 0; w < 50 && grant_n[1] != 1'b0; w++) @(negedge clk);
        repeat (3) @(negedge clk);
        req = '0;
        for (int w = 0; w < 50; w++) begin
            @(negedge clk);
            if (grant_n == '1) break;
        end
        e0 = err_cnt;
        @(negedge clk);
        rogue = 1;
        @(negedge clk);
        rogue = 0;
        repeat (10) @(negedge clk);
        check(err_cnt == e0, "R9 late busy inside window", err_cnt - e0, 0);
        hold_cfg = 2;

        // Random traffic with enable flapping and stray busy pulses
        for (int i = 0; i < 1500; i++) begin
            @(negedge clk);
            if (i % 5 == 0) req = N'($urandom_range(0, (1 << N) - 1));
            arb_en = ($urandom_range(0, 19) != 0);
            rogue  = ($urandom_range(0, 39) == 0);
        end
        rogue = 0; arb_en = 1; req = '0;
        repeat (20) @(negedge clk);

        chk_on = 0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule